// File: doc/BRIEF.md
# Eight-bit shift and rotate unit with flag generation

This block computes the eight shift and rotate operations of the bit-manipulation opcode group of an 8-bit processor. It takes a 3-bit operation code, an 8-bit operand and the current carry flag. It returns the shifted byte and a complete 8-bit flag byte. That flag byte includes the parity flag and the two spare flag positions, which mirror result bits 3 and 5. One of the eight codes selects the rarely documented left shift that inserts a one into bit 0.

The shift and flag logic is combinational. An output register selected by a parameter, on by default, captures the result and flags on each rising clock edge. This lets the surrounding pipeline or a bench sample the outcome one cycle after the inputs are presented. Opcode decode, register selection, memory write-back and instruction timing belong to the surrounding core.

Top module: `shrot_unit`

## Requirements
- R1: Code 0 rotates left, with old bit 7 entering bit 0. Code 1 rotates right, with old bit 0 entering bit 7.
- R2: Code 2 shifts left with the incoming carry entering bit 0. Code 3 shifts right with the incoming carry entering bit 7.
- R3: Code 4 shifts left with a zero entering bit 0. Code 7 shifts right with a zero entering bit 7.
- R4: Code 5 shifts right while keeping old bit 7 in bit 7.
- R5: Code 6 shifts left and forces bit 0 of the result to one.
- R6: Flag bit 0 (carry) receives the bit shifted out. This is old bit 7 for codes 0, 2, 4 and 6, and old bit 0 for codes 1, 3, 5 and 7. The incoming carry has no other effect.
- R7: Flag bit 7 equals result bit 7. Flag bit 6 is one exactly when the result is 0x00.
- R8: Flag bit 2 is one exactly when the result has an even number of one bits.
- R9: Flag bits 3 and 5 copy result bits 3 and 5. Flag bits 1 and 4 are always zero.
- R10: With the output register enabled, the result and flags appear on the rising edge after the inputs. A synchronous active-high reset sets the result to 0x00 and the flags to 0x44.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| shift_kind | input | 3 | Operation code 0..7 |
| operand | input | 8 | Byte to be shifted |
| carry_in | input | 1 | Current carry flag |
| result | output | 8 | Shifted byte |
| flags | output | 8 | Flag byte (S,Z,b5,H,b3,P,N,C from bit 7 down) |

## Verification
The bench sweeps every operand under every code with both carry values, and each result is checked against its own model.

- **Carry feed-in on codes 2 and 3.** A design that fed back the shifted-out bit instead would fail only when the carry differs from that bit, so both carry values are needed.
- **Sign retention on code 5.** A design that dropped the sign bit would pass every operand below 0x80 and fail on the negative half.
- **Forced one on code 6.** A design that treated code 6 as a plain left shift would never set bit 0.
- **Zero and parity flags.** Operands 0x00, 0x01 and 0x80 can collapse to zero, which exposes a zero or parity flag taken from the operand instead of the result.
- **Reset value.** A reset is applied mid-run to confirm the 0x44 value.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    localparam int DATA_W = 8;
    localparam int KIND_W = 3;

    // Flag byte bit positions (fixed by the consumer of the flag byte)
    localparam int FB_CARRY = 0;
    localparam int FB_SUB   = 1;
    localparam int FB_PAR   = 2;
    localparam int FB_B3    = 3;
    localparam int FB_HALF  = 4;
    localparam int FB_B5    = 5;
    localparam int FB_ZERO  = 6;
    localparam int FB_SIGN  = 7;

    // Value the flag byte takes for a zero result with carry clear
    localparam logic [DATA_W-1:0] FLAGS_RST = DATA_W'((1 << FB_ZERO) | (1 << FB_PAR));

    typedef enum logic [KIND_W-1:0] {
        SK_ROT_L  = 3'd0,
        SK_ROT_R  = 3'd1,
        SK_RCY_L  = 3'd2,
        SK_RCY_R  = 3'd3,
        SK_ASH_L  = 3'd4,
        SK_ASH_R  = 3'd5,
        SK_INS1_L = 3'd6,
        SK_LSH_R  = 3'd7
    } shift_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry_out;
    } shift_res_t;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic [DATA_W-1:0] flags;
    } shrot_out_t;

    function automatic logic even_ones(input logic [DATA_W-1:0] v);
        return ~(^v);
    endfunction

    function automatic logic goes_left(input shift_kind_e k);
        return (k == SK_ROT_L) || (k == SK_RCY_L) || (k == SK_ASH_L) || (k == SK_INS1_L);
    endfunction

endpackage

// File: rtl/shrot_core.sv
module shrot_core
    import shrot_pkg::*;
(
    input  shift_kind_e       kind,
    input  logic [DATA_W-1:0] operand,
    input  logic              carry_in,
    output shift_res_t        res
);
    logic fill;
    logic left;

    always_comb begin
        left = goes_left(kind);
        unique case (kind)
            SK_ROT_L:  fill = operand[DATA_W-1];
            SK_ROT_R:  fill = operand[0];
            SK_RCY_L,
            SK_RCY_R:  fill = carry_in;
            SK_ASH_L:  fill = 1'b0;
            SK_ASH_R:  fill = operand[DATA_W-1];
            SK_INS1_L: fill = 1'b1;
            SK_LSH_R:  fill = 1'b0;
            default:   fill = 1'b0;
        endcase
    end

    always_comb begin
        if (left) begin
            res.value     = {operand[DATA_W-2:0], fill};
            res.carry_out = operand[DATA_W-1];
        end else begin
            res.value     = {fill, operand[DATA_W-1:1]};
            res.carry_out = operand[0];
        end
    end

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
    import shrot_pkg::*;
(
    input  logic [DATA_W-1:0] value,
    input  logic              carry_out,
    output logic [DATA_W-1:0] flags
);
    always_comb begin
        flags           = '0;
        flags[FB_CARRY] = carry_out;
        flags[FB_SUB]   = 1'b0;
        flags[FB_PAR]   = even_ones(value);
        flags[FB_B3]    = value[3];
        flags[FB_HALF]  = 1'b0;
        flags[FB_B5]    = value[5];
        flags[FB_ZERO]  = (value == '0);
        flags[FB_SIGN]  = value[DATA_W-1];
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [KIND_W-1:0] shift_kind,
    input  logic [DATA_W-1:0] operand,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] flags
);
    shift_res_t  core_res;
    shrot_out_t  comb_out;
    shrot_out_t  out_q;
    logic [DATA_W-1:0] comb_flags;

    shrot_core u_core (
        .kind     (shift_kind_e'(shift_kind)),
        .operand  (operand),
        .carry_in (carry_in),
        .res      (core_res)
    );

    shrot_flags u_flags (
        .value     (core_res.value),
        .carry_out (core_res.carry_out),
        .flags     (comb_flags)
    );

    assign comb_out.value = core_res.value;
    assign comb_out.flags = comb_flags;

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_q.value <= '0;
                    out_q.flags <= FLAGS_RST;
                end else begin
                    out_q <= comb_out;
                end
            end

            AST_PIPE_VALUE: assert property (@(posedge clk) disable iff (rst)
                !rst |=> result == $past(core_res.value)); // R10
            AST_PIPE_CARRY: assert property (@(posedge clk) disable iff (rst)
                !rst |=> flags[FB_CARRY] == $past(core_res.carry_out)); // R6
        end else begin : g_comb
            assign out_q = comb_out;
        end
    endgenerate

    assign result = out_q.value;
    assign flags  = out_q.flags;

    AST_SIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (flags[FB_SIGN] == result[DATA_W-1]) && (flags[FB_ZERO] == (result == '0))); // R7
    AST_PARITY_EVEN: assert property (@(posedge clk) disable iff (rst)
        flags[FB_PAR] == ($countones(result) % 2 == 0)); // R8
    AST_SPARE_COPY: assert property (@(posedge clk) disable iff (rst)
        flags[FB_B3] == result[3] && flags[FB_B5] == result[5]); // R9
    AST_HN_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !flags[FB_HALF] && !flags[FB_SUB]); // R9
    AST_INS1_BIT0: assert property (@(posedge clk) disable iff (rst)
        (shift_kind == KIND_W'(SK_INS1_L)) |-> core_res.value[0]); // R5
    AST_SRA_SIGN: assert property (@(posedge clk) disable iff (rst)
        (shift_kind == KIND_W'(SK_ASH_R)) |-> core_res.value[DATA_W-1] == operand[DATA_W-1]); // R4

endmodule

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG_CYC = 100000;

    typedef struct {
        logic [7:0] exp_r;
        logic [7:0] exp_f;
        int         kind;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] shift_kind = '0;
    logic [7:0] operand = '0;
    logic       carry_in = 1'b0;
    logic [7:0] result;
    logic [7:0] flags;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    sb_item_t sbq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    shrot_unit u0 (
        .clk(clk), .rst(rst), .shift_kind(shift_kind), .operand(operand),
        .carry_in(carry_in), .result(result), .flags(flags)
    );

    function automatic string kind_req(int k);
        case (k)
            0, 1:    return "R1";
            2, 3:    return "R2";
            4, 7:    return "R3";
            5:       return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic sb_item_t model(int k, logic [7:0] v, logic c);
        sb_item_t it;
        logic [7:0] r;
        logic co;
        case (k)
            0: begin r = {v[6:0], v[7]}; co = v[7]; end
            1: begin r = {v[0], v[7:1]}; co = v[0]; end
            2: begin r = {v[6:0], c};    co = v[7]; end
            3: begin r = {c, v[7:1]};    co = v[0]; end
            4: begin r = {v[6:0], 1'b0}; co = v[7]; end
            5: begin r = {v[7], v[7:1]}; co = v[0]; end
            6: begin r = {v[6:0], 1'b1}; co = v[7]; end
            default: begin r = {1'b0, v[7:1]}; co = v[0]; end
        endcase
        it.exp_r = r;
        it.exp_f = {r[7], (r == 8'h00), r[5], 1'b0, r[3], ~(^r), 1'b0, co};
        it.kind  = k;
        return it;
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic drive(int k, logic [7:0] v, logic c);
        @(negedge clk);
        shift_kind = 3'(k);
        operand    = v;
        carry_in   = c;
        sbq.push_back(model(k, v, c));
    endtask

    // Monitor: output register updates on the posedge after the drive
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                sb_item_t it;
                it = sbq.pop_front();
                check(kind_req(it.kind), result, it.exp_r, "result");
                check("R6", {7'b0, flags[0]}, {7'b0, it.exp_f[0]}, "carry flag");
                check("R7", {flags[7], flags[6]}, {it.exp_f[7], it.exp_f[6]}, "sign/zero");
                check("R8", {7'b0, flags[2]}, {7'b0, it.exp_f[2]}, "parity");
                check("R9", flags & 8'h3A, it.exp_f & 8'h3A, "spare/H/N bits");
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #2;
        check("R10", result, 8'h00, "reset result");
        check("R10", flags, 8'h44, "reset flags");
        @(negedge clk);
        rst = 1'b0;
        // Directed corners
        drive(2, 8'h80, 1'b0);   // R2: result zero, carry out 1
        drive(3, 8'h01, 1'b1);   // R2: carry enters bit 7
        drive(5, 8'h81, 1'b0);   // R4: sign kept
        drive(6, 8'h80, 1'b0);   // R5: forced one
        drive(4, 8'h80, 1'b1);   // R3: zero result despite carry
        drive(7, 8'h01, 1'b1);   // R3
        drive(0, 8'h00, 1'b1);   // R1 / R6: carry in ignored
        // Exhaustive sweep
        for (int k = 0; k < 8; k++)
            for (int c = 0; c < 2; c++)
                for (int v = 0; v < 256; v++)
                    drive(k, 8'(v), 1'(c));
        @(negedge clk);
        @(posedge clk);
        #3;
        // Mid-run reset (R10)
        drive(1, 8'hFF, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check("R10", result, 8'h00, "mid-run reset result");
        check("R10", flags, 8'h44, "mid-run reset flags");
        @(negedge clk);
        rst = 1'b0;
        drive(5, 8'hF0, 1'b0);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule